// File: doc/BRIEF.md
# Block Command Descriptor Parser

This block sits beside a bus-phase sequencer on the target side of a parallel block-storage link. Once the sequencer has gathered a complete 6-byte or 10-byte command descriptor, it presents all ten byte slots for one cycle. The parser decodes the opcode and latches the transfer parameters: direction, block address, block count and byte count. It then tells the sequencer which bus phase to enter next.

For commands that return data, the parser drives a ready/valid byte stream toward the initiator. Read data comes from the media side. Capacity and identification replies are generated inside the block. For writes, the parser counts incoming data bytes until the full transfer has arrived. When a transfer ends, or when a command needs no data phase at all, the parser pulses `done` and requests the status phase with a status code. Media access itself stays outside the block: read and write requests leave as one-cycle pulses that carry the address and the count.

Top module: `cdb_parser`

## Requirements
- R1: After reset the block is idle: `phase_req` is 0 (none), and `busy`, `done`, `din_valid` and `dout_ready` are all 0.
- R2: A read (opcode 0x08) or write (opcode 0x0A) with a valid block count is registered at the clock edge that accepts the command. At that edge:
  - `blk_addr` takes the low 21 bits of the big-endian value {byte1, byte2, byte3}, so the top three bits of byte1 are dropped.
  - `blk_count` takes byte4.
  - `byte_count` takes byte4 × 512.
  - `xfer_to_host` is 1 for a read.
  - Exactly one of `rd_req` and `wr_req` pulses for one cycle.
  - `phase_req` becomes 1 (data-in) for a read or 2 (data-out) for a write.
- R3: A read or write whose byte4 is 0 or above 64 raises no media request. Instead `phase_req` becomes 3 (status), `status_byte` becomes 0x02 (check condition), `cmd_err` becomes 1, `done` pulses and `busy` stays 0.
- R4: During data-in, a read passes `rd_data` to `din_data` and `din_ready` to `rd_ready`. `din_valid` follows `rd_valid`. After exactly `byte_count` handshakes the block returns to idle with `phase_req` 3, `status_byte` 0x00 and a one-cycle `done`.
- R5: During data-out, `dout_ready` is held at 1. After exactly `byte_count` accepted bytes the block requests status 0x00 and pulses `done`.
- R6: Read capacity (opcode 0x25) streams 8 bytes: the block-count parameter as 4 big-endian bytes, then the block size 512 as 4 big-endian bytes.
- R7: The inquiry reply (opcode 0x12) is 36 bytes, in this order:
  - Bytes 0, 1 and 3–7 are 0x00, and byte 2 is 0x49.
  - Bytes 8–15 are the vendor parameter.
  - Bytes 16–31 are the product parameter.
  - Bytes 32–35 are the revision parameter.
  - Each parameter is sent first character first.
- R8: The inquiry transfer length is the smaller of byte4 and 36. If byte4 is below 6, the command ends in check-condition status with no data phase.
- R9: Test unit ready (0x00) and mode select (0x15) go straight to status 0x00, pulse `done` and raise no media request.
- R10: Any other opcode ends in check-condition status 0x02 with `cmd_err` set.
- R11: While `busy` is 1, `cmd_valid` is ignored, and `phase_req` and the transfer in progress are unaffected.
- R12: While `din_valid` is 1 and `din_ready` is 0, `din_data` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Descriptor present, accepted when idle |
| cmd_bytes | input | 80 | Descriptor bytes, byte n at bits 8n+7:8n |
| busy | output | 1 | A data phase is in progress |
| phase_req | output | 2 | Requested phase: 0 none, 1 data-in, 2 data-out, 3 status |
| status_byte | output | 8 | Status code for the status phase |
| cmd_err | output | 1 | Last command was rejected |
| done | output | 1 | One-cycle pulse when status is requested |
| xfer_to_host | output | 1 | Last accepted transfer moves data toward the initiator |
| blk_addr | output | ADDR_W (21) | Media block address |
| blk_count | output | 8 | Media block count |
| byte_count | output | LEN_W (16) | Bytes in the data phase |
| rd_req | output | 1 | Media read request pulse |
| wr_req | output | 1 | Media write request pulse |
| rd_valid | input | 1 | Media read byte valid |
| rd_data | input | 8 | Media read byte |
| rd_ready | output | 1 | Media read byte taken |
| din_valid | output | 1 | Data-in byte valid |
| din_data | output | 8 | Data-in byte |
| din_ready | input | 1 | Sequencer takes the data-in byte |
| dout_valid | input | 1 | Data-out byte arrives |
| dout_ready | output | 1 | Data-out byte accepted |

## Verification
The data-hold property assumes a well-behaved media source. Once that source offers a byte on `rd_data`, it keeps the byte steady until `rd_ready` takes it. The bench respects this by recomputing `rd_data` only from the index of the next byte it expects, and that index moves only on a completed handshake. The other properties rely on the sequencer presenting a descriptor as a single-cycle `cmd_valid`, apart from one deliberate, held intrusion during a long read. The random mix keeps block counts small, which keeps the run short. A single directed 64-block read covers the largest transfer.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

   typedef enum logic [1:0] {
      PH_NONE     = 2'd0,
      PH_DATA_IN  = 2'd1,
      PH_DATA_OUT = 2'd2,
      PH_STATUS   = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      SRC_READ = 2'd0,
      SRC_CAP  = 2'd1,
      SRC_INQ  = 2'd2,
      SRC_NONE = 2'd3
   } src_t;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_DIN  = 2'd1,
      XS_DOUT = 2'd2
   } xstate_t;

   typedef struct packed {
      phase_t next_phase;
      src_t   src;
      logic   err;
      logic   rd;
      logic   wr;
   } decode_t;

   localparam logic [7:0] OP_TEST_READY = 8'h00;
   localparam logic [7:0] OP_READ6      = 8'h08;
   localparam logic [7:0] OP_WRITE6     = 8'h0A;
   localparam logic [7:0] OP_INQUIRY    = 8'h12;
   localparam logic [7:0] OP_MODE_SEL   = 8'h15;
   localparam logic [7:0] OP_CAPACITY   = 8'h25;

   localparam logic [7:0] ST_GOOD  = 8'h00;
   localparam logic [7:0] ST_CHECK = 8'h02;

   localparam int INQ_LEN = 36;
   localparam int INQ_MIN = 6;
   localparam int CAP_LEN = 8;

   // version byte: iso=1 (2b), ecma=1 (3b), ansi=1 (3b)
   localparam logic [7:0] INQ_VERSION = {2'd1, 3'd1, 3'd1};

endpackage

// File: rtl/cdb_decode.sv
module cdb_decode
   import cdb_pkg::*;
#(
   parameter int MAX_BLOCKS  = 64,
   parameter int BLOCK_BYTES = 512,
   parameter int ADDR_W      = 21,
   parameter int LEN_W       = 16
) (
   input  logic [79:0]       cmd,
   output decode_t           dec,
   output logic [ADDR_W-1:0] lba,
   output logic [7:0]        blocks,
   output logic [LEN_W-1:0]  len
);

   logic [7:0]  op;
   logic [7:0]  b4;
   logic [23:0] lba_full;
   logic        cnt_ok;
   logic        unused_bits;

   assign op       = cmd[7:0];
   assign b4       = cmd[39:32];
   assign cnt_ok   = (b4 != 8'd0) && (int'(b4) <= MAX_BLOCKS);
   assign lba      = lba_full[ADDR_W-1:0];
   assign unused_bits = ^{cmd[79:40], lba_full};

   always_comb begin
      dec.next_phase = PH_STATUS;
      dec.src        = SRC_NONE;
      dec.err        = 1'b0;
      dec.rd         = 1'b0;
      dec.wr         = 1'b0;
      lba_full       = '0;
      blocks         = '0;
      len            = '0;
      case (op)
         OP_TEST_READY, OP_MODE_SEL: begin
            dec.next_phase = PH_STATUS;
         end
         OP_READ6, OP_WRITE6: begin
            if (cnt_ok) begin
               lba_full = {cmd[15:8], cmd[23:16], cmd[31:24]};
               blocks   = b4;
               len      = LEN_W'(b4) * LEN_W'(BLOCK_BYTES);
               if (op == OP_READ6) begin
                  dec.next_phase = PH_DATA_IN;
                  dec.src        = SRC_READ;
                  dec.rd         = 1'b1;
               end else begin
                  dec.next_phase = PH_DATA_OUT;
                  dec.wr         = 1'b1;
               end
            end else begin
               dec.err = 1'b1;
            end
         end
         OP_CAPACITY: begin
            dec.next_phase = PH_DATA_IN;
            dec.src        = SRC_CAP;
            len            = LEN_W'(CAP_LEN);
         end
         OP_INQUIRY: begin
            if (int'(b4) < INQ_MIN) begin
               dec.err = 1'b1;
            end else begin
               dec.next_phase = PH_DATA_IN;
               dec.src        = SRC_INQ;
               len = (int'(b4) > INQ_LEN) ? LEN_W'(INQ_LEN) : LEN_W'(b4);
            end
         end
         default: dec.err = 1'b1;
      endcase
   end

endmodule

// File: rtl/cdb_resp_gen.sv
module cdb_resp_gen
   import cdb_pkg::*;
#(
   parameter logic [31:0]  CAP_BLOCKS  = 32'h0000_4000,
   parameter int           BLOCK_BYTES = 512,
   parameter logic [63:0]  VENDOR_ID   = "GENERIC ",
   parameter logic [127:0] PRODUCT_ID  = "BLOCK TARGET    ",
   parameter logic [31:0]  REVISION_ID = "0001"
) (
   input  src_t       src,
   input  logic [5:0] idx,
   input  logic [7:0] media_byte,
   output logic [7:0] byte_o
);

   localparam logic [63:0] CAP_WORD = {CAP_BLOCKS, 32'(BLOCK_BYTES)};

   logic [7:0] inq_tbl [INQ_LEN];
   logic [7:0] cap_tbl [CAP_LEN];

   for (genvar i = 0; i < INQ_LEN; i++) begin : g_inq
      if (i == 2) begin : g_ver
         assign inq_tbl[i] = INQ_VERSION;
      end else if (i < 8) begin : g_hdr
         assign inq_tbl[i] = 8'h00;
      end else if (i < 16) begin : g_vid
         assign inq_tbl[i] = VENDOR_ID[8*(16-i)-1 -: 8];
      end else if (i < 32) begin : g_pid
         assign inq_tbl[i] = PRODUCT_ID[8*(32-i)-1 -: 8];
      end else begin : g_rev
         assign inq_tbl[i] = REVISION_ID[8*(36-i)-1 -: 8];
      end
   end

   for (genvar j = 0; j < CAP_LEN; j++) begin : g_cap
      assign cap_tbl[j] = CAP_WORD[8*(CAP_LEN-j)-1 -: 8];
   end

   always_comb begin
      byte_o = 8'h00;
      case (src)
         SRC_READ: byte_o = media_byte;
         SRC_CAP:  if (int'(idx) < CAP_LEN) byte_o = cap_tbl[idx[2:0]];
         SRC_INQ:  if (int'(idx) < INQ_LEN) byte_o = inq_tbl[idx];
         default:  byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/cdb_xfer_ctrl.sv
module cdb_xfer_ctrl
   import cdb_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  decode_t           dec,
   input  logic [ADDR_W-1:0] lba,
   input  logic [7:0]        blocks,
   input  logic [LEN_W-1:0]  len,
   input  logic              din_ready,
   input  logic              rd_valid,
   input  logic              dout_valid,
   output logic              busy,
   output src_t              src_q,
   output logic [LEN_W-1:0]  idx_q,
   output logic              din_valid,
   output logic              rd_ready,
   output logic              dout_ready,
   output phase_t            phase_q,
   output logic [7:0]        status_q,
   output logic              err_q,
   output logic              done_q,
   output logic              rd_req_q,
   output logic              wr_req_q,
   output logic              to_host_q,
   output logic [ADDR_W-1:0] lba_q,
   output logic [7:0]        blocks_q,
   output logic [LEN_W-1:0]  len_q
);

   xstate_t state_q;
   logic    accept;
   logic    beat;
   logic    last;

   assign busy       = (state_q != XS_IDLE);
   assign accept     = cmd_valid && (state_q == XS_IDLE);
   assign din_valid  = (state_q == XS_DIN) && ((src_q != SRC_READ) || rd_valid);
   assign rd_ready   = (state_q == XS_DIN) && (src_q == SRC_READ) && din_ready;
   assign dout_ready = (state_q == XS_DOUT);
   assign beat       = (din_valid && din_ready) || (dout_valid && dout_ready);
   assign last       = (idx_q == len_q - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= XS_IDLE;
         src_q     <= SRC_NONE;
         idx_q     <= '0;
         phase_q   <= PH_NONE;
         status_q  <= ST_GOOD;
         err_q     <= 1'b0;
         done_q    <= 1'b0;
         rd_req_q  <= 1'b0;
         wr_req_q  <= 1'b0;
         to_host_q <= 1'b0;
         lba_q     <= '0;
         blocks_q  <= '0;
         len_q     <= '0;
      end else begin
         done_q   <= 1'b0;
         rd_req_q <= 1'b0;
         wr_req_q <= 1'b0;
         if (accept) begin
            src_q     <= dec.src;
            idx_q     <= '0;
            phase_q   <= dec.next_phase;
            err_q     <= dec.err;
            rd_req_q  <= dec.rd;
            wr_req_q  <= dec.wr;
            lba_q     <= lba;
            blocks_q  <= blocks;
            len_q     <= len;
            to_host_q <= (dec.next_phase == PH_DATA_IN);
            case (dec.next_phase)
               PH_DATA_IN:  state_q <= XS_DIN;
               PH_DATA_OUT: state_q <= XS_DOUT;
               default: begin
                  state_q  <= XS_IDLE;
                  status_q <= dec.err ? ST_CHECK : ST_GOOD;
                  done_q   <= 1'b1;
               end
            endcase
         end else if (beat) begin
            if (last) begin
               state_q  <= XS_IDLE;
               idx_q    <= '0;
               phase_q  <= PH_STATUS;
               status_q <= ST_GOOD;
               done_q   <= 1'b1;
            end else begin
               idx_q <= idx_q + LEN_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/cdb_parser.sv
module cdb_parser
   import cdb_pkg::*;
#(
   parameter int           MAX_BLOCKS  = 64,
   parameter int           BLOCK_BYTES = 512,
   parameter int           ADDR_W      = 21,
   parameter logic [31:0]  CAP_BLOCKS  = 32'h0000_4000,
   parameter logic [63:0]  VENDOR_ID   = "GENERIC ",
   parameter logic [127:0] PRODUCT_ID  = "BLOCK TARGET    ",
   parameter logic [31:0]  REVISION_ID = "0001",
   localparam int LEN_RAW = $clog2(MAX_BLOCKS * BLOCK_BYTES + 1),
   localparam int LEN_W   = (LEN_RAW > 6) ? LEN_RAW : 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [79:0]       cmd_bytes,
   output logic              busy,
   output logic [1:0]        phase_req,
   output logic [7:0]        status_byte,
   output logic              cmd_err,
   output logic              done,
   output logic              xfer_to_host,
   output logic [ADDR_W-1:0] blk_addr,
   output logic [7:0]        blk_count,
   output logic [LEN_W-1:0]  byte_count,
   output logic              rd_req,
   output logic              wr_req,
   input  logic              rd_valid,
   input  logic [7:0]        rd_data,
   output logic              rd_ready,
   output logic              din_valid,
   output logic [7:0]        din_data,
   input  logic              din_ready,
   input  logic              dout_valid,
   output logic              dout_ready
);

   if (MAX_BLOCKS < 1 || MAX_BLOCKS > 255) begin : g_bad_max
      $error("cdb_parser: MAX_BLOCKS must lie in 1..255");
   end
   if (BLOCK_BYTES < 1 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("cdb_parser: BLOCK_BYTES must be a power of two");
   end
   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("cdb_parser: ADDR_W must lie in 1..24");
   end

   decode_t           dec;
   logic [ADDR_W-1:0] dec_lba;
   logic [7:0]        dec_blocks;
   logic [LEN_W-1:0]  dec_len;
   src_t              src_q;
   logic [LEN_W-1:0]  idx_q;
   phase_t            phase_q;
   logic              unused_idx;

   assign unused_idx = ^idx_q;
   assign phase_req  = phase_q;

   cdb_decode #(
      .MAX_BLOCKS (MAX_BLOCKS),
      .BLOCK_BYTES(BLOCK_BYTES),
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W)
   ) u_decode (
      .cmd   (cmd_bytes),
      .dec   (dec),
      .lba   (dec_lba),
      .blocks(dec_blocks),
      .len   (dec_len)
   );

   cdb_xfer_ctrl #(
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .dec       (dec),
      .lba       (dec_lba),
      .blocks    (dec_blocks),
      .len       (dec_len),
      .din_ready (din_ready),
      .rd_valid  (rd_valid),
      .dout_valid(dout_valid),
      .busy      (busy),
      .src_q     (src_q),
      .idx_q     (idx_q),
      .din_valid (din_valid),
      .rd_ready  (rd_ready),
      .dout_ready(dout_ready),
      .phase_q   (phase_q),
      .status_q  (status_byte),
      .err_q     (cmd_err),
      .done_q    (done),
      .rd_req_q  (rd_req),
      .wr_req_q  (wr_req),
      .to_host_q (xfer_to_host),
      .lba_q     (blk_addr),
      .blocks_q  (blk_count),
      .len_q     (byte_count)
   );

   cdb_resp_gen #(
      .CAP_BLOCKS (CAP_BLOCKS),
      .BLOCK_BYTES(BLOCK_BYTES),
      .VENDOR_ID  (VENDOR_ID),
      .PRODUCT_ID (PRODUCT_ID),
      .REVISION_ID(REVISION_ID)
   ) u_resp (
      .src       (src_q),
      .idx       (idx_q[5:0]),
      .media_byte(rd_data),
      .byte_o    (din_data)
   );

endmodule

// File: rtl/cdb_parser_chk.sv
module cdb_parser_chk #(
   parameter int MAX_BLOCKS = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic [1:0] phase_req,
   input logic [7:0] status_byte,
   input logic       cmd_err,
   input logic       done,
   input logic [7:0] blk_count,
   input logic       rd_req,
   input logic       wr_req,
   input logic       din_valid,
   input logic [7:0] din_data,
   input logic       din_ready,
   input logic       dout_ready
);

   AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase_req == 2'd3) && !busy);  // R4

   AST_ERR_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> (status_byte == 8'h02));  // R3

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, wr_req}));  // R2

   AST_REQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || wr_req) |-> (blk_count != 8'd0) && (int'(blk_count) <= MAX_BLOCKS));  // R3

   AST_DIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (din_valid && !din_ready) |=> $stable(din_data));  // R12

   AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(din_valid && dout_ready));  // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !din_valid && !dout_ready);  // R11

   AST_BUSY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(phase_req));  // R11

endmodule

bind cdb_parser cdb_parser_chk #(.MAX_BLOCKS(MAX_BLOCKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .phase_req  (phase_req),
   .status_byte(status_byte),
   .cmd_err    (cmd_err),
   .done       (done),
   .blk_count  (blk_count),
   .rd_req     (rd_req),
   .wr_req     (wr_req),
   .din_valid  (din_valid),
   .din_data   (din_data),
   .din_ready  (din_ready),
   .dout_ready (dout_ready)
);

// File: tb/tb_cdb_parser.sv
module tb_cdb_parser;

   localparam logic [31:0]  T_CAP = 32'h0001_2345;
   localparam logic [63:0]  T_VID = "TESTVEND";
   localparam logic [127:0] T_PID = "SPARSE DISK UNIT";
   localparam logic [31:0]  T_REV = "R0.1";

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [79:0] cmd_bytes = '0;
   logic        busy;
   logic [1:0]  phase_req;
   logic [7:0]  status_byte;
   logic        cmd_err;
   logic        done;
   logic        xfer_to_host;
   logic [20:0] blk_addr;
   logic [7:0]  blk_count;
   logic [15:0] byte_count;
   logic        rd_req;
   logic        wr_req;
   logic        rd_valid = 1'b0;
   logic [7:0]  rd_data = '0;
   logic        rd_ready;
   logic        din_valid;
   logic [7:0]  din_data;
   logic        din_ready = 1'b0;
   logic        dout_valid = 1'b0;
   logic        dout_ready;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cdb_parser #(
      .CAP_BLOCKS (T_CAP),
      .VENDOR_ID  (T_VID),
      .PRODUCT_ID (T_PID),
      .REVISION_ID(T_REV)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bytes(cmd_bytes),
      .busy(busy), .phase_req(phase_req), .status_byte(status_byte),
      .cmd_err(cmd_err), .done(done), .xfer_to_host(xfer_to_host),
      .blk_addr(blk_addr), .blk_count(blk_count), .byte_count(byte_count),
      .rd_req(rd_req), .wr_req(wr_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_ready(rd_ready), .din_valid(din_valid), .din_data(din_data),
      .din_ready(din_ready), .dout_valid(dout_valid), .dout_ready(dout_ready)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k);
      return 8'(k) ^ 8'hA5 ^ 8'(k >> 8);
   endfunction

   function automatic logic [7:0] ref_inq(input int i);
      if (i == 2) return 8'h49;
      if (i < 8) return 8'h00;
      if (i < 16) return T_VID[8*(16-i)-1 -: 8];
      if (i < 32) return T_PID[8*(32-i)-1 -: 8];
      return T_REV[8*(36-i)-1 -: 8];
   endfunction

   function automatic logic [7:0] ref_cap(input int i);
      logic [63:0] w;
      w = {T_CAP, 32'd512};
      return w[8*(8-i)-1 -: 8];
   endfunction

   function automatic logic [7:0] ref_byte(input logic [7:0] op, input int k);
      if (op == 8'h08) return pat(k);
      if (op == 8'h25) return ref_cap(k);
      return ref_inq(k);
   endfunction

   task automatic send_cmd(input logic [7:0] op, b1, b2, b3, b4);
      @(negedge clk);
      cmd_bytes = {40'h0, b4, b3, b2, b1, op};
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run_din(input logic [7:0] op, input int n, input int rdy_pct,
                          input bit intrude, input string tag);
      int  k = 0;
      bit  stall = 0;
      logic [7:0] prev = '0;
      while (k < n) begin
         @(negedge clk);
         din_ready = (($urandom % 100) < rdy_pct);
         rd_valid  = (($urandom % 100) < 80);
         rd_data   = pat(k);
         cmd_valid = intrude && (k == 2);
         cmd_bytes = {40'h0, 8'd36, 24'h0, 8'h12};
         #1;
         if (stall) chk(din_data, prev, "R12 held data-in byte");
         if (op == 8'h08) begin
            chk(din_valid, rd_valid, "R4 valid follows media");
            chk(rd_ready, din_ready, "R4 ready passes to media");
         end
         if (intrude && k >= 2 && k < 5) begin
            chk(phase_req, 2'd1, "R11 phase kept while busy");
            chk(busy, 1'b1, "R11 still busy");
         end
         stall = din_valid && !din_ready;
         prev  = din_data;
         if (din_valid && din_ready) begin
            chk(din_data, ref_byte(op, k), tag);
            k++;
         end
      end
      @(negedge clk);
      din_ready = 1'b0;
      rd_valid  = 1'b0;
      cmd_valid = 1'b0;
      #1;
      chk(done, 1'b1, "R4 done after data-in");
      chk(phase_req, 2'd3, "R4 status after data-in");
      chk(status_byte, 8'h00, "R4 good status");
      chk(busy, 1'b0, "R4 idle after data-in");
   endtask

   task automatic run_dout(input int n);
      int k = 0;
      while (k < n) begin
         @(negedge clk);
         dout_valid = (($urandom % 100) < 70);
         #1;
         if (k == 0 || k == n - 1) chk(dout_ready, 1'b1, "R5 ready in data-out");
         if (dout_valid && dout_ready) k++;
      end
      @(negedge clk);
      dout_valid = 1'b0;
      #1;
      chk(done, 1'b1, "R5 done after data-out");
      chk(phase_req, 2'd3, "R5 status after data-out");
      chk(status_byte, 8'h00, "R5 good status");
      chk(dout_ready, 1'b0, "R5 ready drops");
   endtask

   task automatic do_cmd(input logic [7:0] op, b1, b2, b3, b4,
                         input int rdy_pct, input bit intrude);
      logic [1:0] ph;
      int         len;
      bit         err;
      string      tg;
      ph = 2'd3; len = 0; err = 0; tg = "R10";
      case (op)
         8'h00, 8'h15: tg = "R9";
         8'h08, 8'h0A: begin
            if (b4 == 0 || b4 > 64) begin err = 1; tg = "R3"; end
            else begin
               ph = (op == 8'h08) ? 2'd1 : 2'd2;
               len = int'(b4) * 512;
               tg = "R2";
            end
         end
         8'h25: begin ph = 2'd1; len = 8; tg = "R6"; end
         8'h12: begin
            tg = "R8";
            if (b4 < 6) err = 1;
            else begin ph = 2'd1; len = (b4 > 36) ? 36 : int'(b4); end
         end
         default: err = 1;
      endcase
      send_cmd(op, b1, b2, b3, b4);
      #1;
      chk(phase_req, ph, {tg, " phase request"});
      if (ph == 2'd3) begin
         chk(done, 1'b1, {tg, " done pulse"});
         chk(status_byte, err ? 8'h02 : 8'h00, {tg, " status code"});
         chk(cmd_err, err, {tg, " error flag"});
         chk({rd_req, wr_req}, 2'b00, {tg, " no media request"});
         chk(busy, 1'b0, {tg, " not busy"});
      end else begin
         chk(busy, 1'b1, {tg, " busy"});
         chk(byte_count, len, {tg, " byte count"});
         if (op == 8'h08 || op == 8'h0A) begin
            chk(blk_addr, {b1[4:0], b2, b3}, "R2 block address");
            chk(blk_count, b4, "R2 block count");
            chk(rd_req, op == 8'h08, "R2 read request");
            chk(wr_req, op == 8'h0A, "R2 write request");
            chk(xfer_to_host, op == 8'h08, "R2 direction");
         end
         if (ph == 2'd1)
            run_din(op, len, rdy_pct, intrude,
                    (op == 8'h08) ? "R4 read byte" : (op == 8'h25) ? "R6 capacity byte" : "R7 inquiry byte");
         else
            run_dout(len);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(phase_req, 2'd0, "R1 reset phase");
      chk(busy, 1'b0, "R1 reset busy");
      chk(done, 1'b0, "R1 reset done");
      chk(din_valid, 1'b0, "R1 reset din_valid");
      chk(dout_ready, 1'b0, "R1 reset dout_ready");

      do_cmd(8'h12, 0, 0, 0, 8'd36, 60, 0);
      do_cmd(8'h12, 0, 0, 0, 8'd6, 60, 0);
      do_cmd(8'h12, 0, 0, 0, 8'd5, 60, 0);
      do_cmd(8'h12, 0, 0, 0, 8'd255, 60, 0);
      do_cmd(8'h25, 0, 0, 0, 0, 50, 0);
      do_cmd(8'h00, 0, 0, 0, 0, 50, 0);
      do_cmd(8'h15, 0, 0, 0, 8'd12, 50, 0);
      do_cmd(8'h03, 0, 0, 0, 0, 50, 0);
      do_cmd(8'h08, 8'hFF, 8'h12, 8'h34, 8'd64, 100, 1);
      do_cmd(8'h0A, 8'h1F, 8'hFF, 8'hFF, 8'd1, 50, 0);
      do_cmd(8'h08, 8'h00, 8'h00, 8'h01, 8'd65, 50, 0);
      do_cmd(8'h0A, 8'h00, 8'h00, 8'h01, 8'd0, 50, 0);

      for (int it = 0; it < 16; it++) begin
         int kind;
         logic [7:0] c1, c2, c3, n;
         kind = int'($urandom % 6);
         c1 = 8'($urandom); c2 = 8'($urandom); c3 = 8'($urandom);
         n  = 8'(1 + $urandom % 4);
         case (kind)
            0: do_cmd(8'h08, c1, c2, c3, n, 75, 0);
            1: do_cmd(8'h0A, c1, c2, c3, n, 75, 0);
            2: do_cmd(8'h12, 0, 0, 0, 8'($urandom % 64), 70, 0);
            3: do_cmd(8'h25, 0, 0, 0, 0, 70, 0);
            4: do_cmd(($urandom % 2) ? 8'h00 : 8'h15, c1, c2, c3, n, 70, 0);
            default: do_cmd(($urandom % 2) ? 8'h08 : 8'h0A, c1, c2, c3,
                            ($urandom % 2) ? 8'd0 : 8'(65 + $urandom % 191), 70, 0);
         endcase
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule